// File: doc/BRIEF.md
# Dual-Port RAM with Collision Flags

This block is a synchronous memory with two ports, A and B. Each port has its own enable, write enable, address, write data and registered read data. Either port may read or write any word in any clock cycle. Depth is set by a parameter to 1024, 2048, 4096 or 8192 words, and width is set to 1, 8 or 16 bits.

Each address splits into two fields. The low four bits select a column and the remaining high bits select a row. A 1024-word memory therefore has 64 rows of 16 columns. When both ports are enabled in the same cycle, a collision detector compares their fields.

- If the two ports address the same word, the hard-busy flag goes high and port A wins.
- If they address different words that share a row or a column, the soft-busy flag goes high as a warning only, and both accesses complete normally.

Both flags are registered, so each one lines up with the read data of the access that caused it.

Top module: `dpram_collide`

## Requirements
- R1: When a port is enabled with write enable high, it stores its write data at its address at the clock edge. When a port is enabled with write enable low, it reads. The read data appears one clock after the access. A port that writes returns its own write data on its read output in that next cycle.
- R2: A port whose enable is low changes no word of the memory. Its read data holds its last value.
- R3: When both ports are enabled and their addresses are equal, the hard-busy output is 1 in the following cycle and the soft-busy output is 0.
- R4: When both ports are enabled and their addresses differ, the soft-busy output is 1 in the following cycle if either of these holds: the low four bits (the column) are equal, or the upper bits (the row) are equal. Both accesses then complete as if alone.
- R5: On a same-word access where port A writes, the word takes A's data and any write from B is discarded. B's read data in the next cycle equals A's write data.
- R6: On a same-word access where port A reads and B writes, B's write is suppressed. Both read outputs return the value the word held before that cycle.
- R7: While either port is disabled, both busy outputs are 0 in the following cycle, even when the addresses match.
- R8: Synchronous reset clears both read outputs and both busy outputs to 0 one clock later. The memory contents are kept.
- R9: When both ports are enabled and both the row and the column differ, both busy outputs are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | $clog2(DEPTH) | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | $clog2(DEPTH) | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B registered read data |
| busy_hard | output | 1 | Same-word collision flag, registered |
| busy_soft | output | 1 | Same-row or same-column warning, registered |

## Verification
Every result of this block is due exactly one rising edge after the access that causes it. That holds for both read outputs and for both busy flags, and equally for the clearing done by reset. The bench drives a whole access on the falling edge. At the next rising edge its reference model works out the read data and the flags for that access, and it compares them at the following falling edge, before the next access is applied. A word written in one cycle is read back no earlier than the next access, so suppressed and overriding writes show up in the read data of a later cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Width of the column field taken from the low address bits.
  localparam int unsigned COL_FIELD_W = 4;

  // Outcome of comparing the two accesses made in one cycle.
  typedef enum logic [1:0] {
    CLASH_NONE = 2'd0,
    CLASH_SOFT = 2'd1,
    CLASH_HARD = 2'd2
  } clash_e;

endpackage

// File: rtl/dpram_addr_split.sv
module dpram_addr_split #(
  parameter int unsigned AW = 10,
  parameter int unsigned CB = 4,
  localparam int unsigned RB = AW - CB
) (
  input  logic [AW-1:0] addr,
  output logic [RB-1:0] row,
  output logic [CB-1:0] col
);

  assign col = addr[CB-1:0];
  assign row = addr[AW-1:CB];

endmodule

// File: rtl/dpram_clash_det.sv
module dpram_clash_det
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned CB = COL_FIELD_W,
  localparam int unsigned RB = AW - CB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output clash_e        clash,
  output logic          busy_hard,
  output logic          busy_soft
);

  logic [AW-1:0] addr_v [2];
  logic [RB-1:0] row_v  [2];
  logic [CB-1:0] col_v  [2];

  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  for (genvar p = 0; p < 2; p++) begin : g_split
    dpram_addr_split #(.AW(AW), .CB(CB)) u_split (
      .addr (addr_v[p]),
      .row  (row_v[p]),
      .col  (col_v[p])
    );
  end

  logic both_on, row_eq, col_eq;

  assign both_on = a_en && b_en;
  assign row_eq  = (row_v[0] == row_v[1]);
  assign col_eq  = (col_v[0] == col_v[1]);

  always_comb begin
    clash = CLASH_NONE;
    if (both_on) begin
      if (row_eq && col_eq)      clash = CLASH_HARD;
      else if (row_eq || col_eq) clash = CLASH_SOFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_hard <= 1'b0;
      busy_soft <= 1'b0;
    end else begin
      busy_hard <= (clash == CLASH_HARD);
      busy_soft <= (clash == CLASH_SOFT);
    end
  end

  p_hard_on_match_r3: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && a_addr == b_addr) |=> (busy_hard && !busy_soft));

  p_soft_on_share_r4: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && a_addr != b_addr &&
     (a_addr[CB-1:0] == b_addr[CB-1:0] || a_addr[AW-1:CB] == b_addr[AW-1:CB]))
    |=> (busy_soft && !busy_hard));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(a_en && b_en) |=> (!busy_hard && !busy_soft));

  p_apart_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && a_addr[CB-1:0] != b_addr[CB-1:0] &&
     a_addr[AW-1:CB] != b_addr[AW-1:CB]) |=> (!busy_hard && !busy_soft));

  p_reset_flags_r8: assert property (@(posedge clk)
    rst |=> (!busy_hard && !busy_soft));

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic             b_fwd,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Write ports: a_wr and b_wr are already qualified, never the same word.
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  // Registered read ports, write-first on own data.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
    end else if (a_en) begin
      a_rdata <= a_wr ? a_wdata : mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else if (b_en) begin
      if (b_fwd)     b_rdata <= a_wdata;
      else if (b_wr) b_rdata <= b_wdata;
      else           b_rdata <= mem[b_addr];
    end
  end

  p_own_write_echo_r1: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> (a_rdata == $past(a_wdata)));

  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> $stable(a_rdata));

  p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> $stable(b_rdata));

  p_reset_rdata_r8: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0));

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
  import dpram_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             busy_hard,
  output logic             busy_soft
);

  clash_e clash;
  logic   a_wr, b_wr, b_fwd;

  dpram_clash_det #(.AW(AW), .CB(COL_FIELD_W)) u_det (
    .clk       (clk),
    .rst       (rst),
    .a_en      (a_en),
    .a_addr    (a_addr),
    .b_en      (b_en),
    .b_addr    (b_addr),
    .clash     (clash),
    .busy_hard (busy_hard),
    .busy_soft (busy_soft)
  );

  // Port A always wins a same-word clash; B's write is dropped there.
  assign a_wr  = a_en && a_we;
  assign b_wr  = b_en && b_we && (clash != CLASH_HARD);
  assign b_fwd = (clash == CLASH_HARD) && a_we;

  dpram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .a_en    (a_en),
    .a_wr    (a_wr),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (b_en),
    .b_wr    (b_wr),
    .b_fwd   (b_fwd),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  p_a_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_we && b_en && a_addr == b_addr) |=> (b_rdata == $past(a_wdata)));

  p_b_echo_r6: assert property (@(posedge clk) disable iff (rst)
    (a_en && !a_we && b_en && b_we && a_addr == b_addr) |=> (b_rdata == a_rdata));

endmodule

// File: tb/test_dpram_collide.sv
module test_dpram_collide;

  localparam int DEPTH = 1024;
  localparam int WIDTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CB    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [AW-1:0]    a_addr = '0, b_addr = '0;
  logic [WIDTH-1:0] a_wdata = '0, b_wdata = '0;
  logic [WIDTH-1:0] a_rdata, b_rdata;
  logic             busy_hard, busy_soft;

  always #4 clk = ~clk;

  dpram_collide #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_dpram_collide (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .busy_hard(busy_hard), .busy_soft(busy_soft)
  );

  int checks = 0;
  int errors = 0;

  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] exp_a = '0, exp_b = '0;
  logic             exp_h = 1'b0, exp_s = 1'b0;

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Behavioural reference: one call models one clock edge.
  task automatic cycle(input string req);
    bit both, same, shr;
    @(posedge clk);
    if (rst) begin
      exp_a = '0; exp_b = '0; exp_h = 1'b0; exp_s = 1'b0;
    end else begin
      both = a_en && b_en;
      same = (a_addr == b_addr);
      shr  = (a_addr[CB-1:0] == b_addr[CB-1:0]) || (a_addr[AW-1:CB] == b_addr[AW-1:CB]);
      exp_h = both && same;
      exp_s = both && !same && shr;
      if (a_en) exp_a = a_we ? a_wdata : model[a_addr];
      if (b_en) begin
        if (exp_h && a_we)      exp_b = a_wdata;
        else if (exp_h)         exp_b = model[b_addr];
        else if (b_we)          exp_b = b_wdata;
        else                    exp_b = model[b_addr];
      end
      if (a_en && a_we) model[a_addr] = a_wdata;
      if (b_en && b_we && !exp_h) model[b_addr] = b_wdata;
    end
    @(negedge clk);
    check(req, "a_rdata", int'(a_rdata), int'(exp_a));
    check(req, "b_rdata", int'(b_rdata), int'(exp_b));
    check(req, "busy_hard", int'(busy_hard), int'(exp_h));
    check(req, "busy_soft", int'(busy_soft), int'(exp_s));
  endtask

  task automatic drive(input bit ae, input bit aw, input int aa, input int ad,
                       input bit be, input bit bw, input int ba, input int bd);
    a_en = ae; a_we = aw; a_addr = AW'(aa); a_wdata = WIDTH'(ad);
    b_en = be; b_we = bw; b_addr = AW'(ba); b_wdata = WIDTH'(bd);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state of outputs
    repeat (3) cycle("R8");
    @(negedge clk);
    rst = 1'b0;

    // R1 and R4: fill every word; A low half, B high half share the column
    for (int i = 0; i < DEPTH / 2; i++) begin
      drive(1, 1, i, i * 3 + 1, 1, 1, i + DEPTH / 2, i * 5 + 7);
      cycle("R1");
    end

    // R1: plain reads from both ports, row and column both differ (R9)
    drive(1, 0, 16'h021, 0, 1, 0, 16'h132, 0); cycle("R9");
    drive(1, 0, 16'h3ff, 0, 1, 0, 16'h000, 0); cycle("R1");

    // R4: same row, different column; same column, different row
    drive(1, 1, 16'h045, 16'hA5A5, 1, 1, 16'h04a, 16'h5A5A); cycle("R4");
    drive(1, 0, 16'h045, 0, 1, 0, 16'h04a, 0); cycle("R4");
    drive(1, 1, 16'h017, 16'h1111, 1, 1, 16'h2a7, 16'h2222); cycle("R4");
    drive(1, 0, 16'h2a7, 0, 1, 0, 16'h017, 0); cycle("R4");

    // R3 and R5: same word, both write, A wins and B sees A's data
    drive(1, 1, 16'h123, 16'hBEEF, 1, 1, 16'h123, 16'hDEAD); cycle("R5");
    drive(1, 0, 16'h123, 0, 1, 0, 16'h123, 0); cycle("R3");

    // R5: A writes, B reads same word
    drive(1, 1, 16'h0aa, 16'h7777, 1, 0, 16'h0aa, 0); cycle("R5");

    // R6: A reads, B writes same word; the write is dropped
    drive(1, 0, 16'h0bb, 0, 1, 1, 16'h0bb, 16'hCAFE); cycle("R6");
    drive(0, 0, 0, 0, 1, 0, 16'h0bb, 0); cycle("R6");

    // R7: matching addresses with one port disabled
    drive(0, 0, 16'h055, 0, 1, 0, 16'h055, 0); cycle("R7");
    drive(1, 1, 16'h055, 16'h4242, 0, 1, 16'h055, 16'h9999); cycle("R7");

    // R2: disabled port's write is ignored, its read data holds
    drive(0, 1, 16'h066, 16'hFFFF, 1, 0, 16'h300, 0); cycle("R2");
    drive(1, 0, 16'h066, 0, 0, 1, 16'h066, 16'h0F0F); cycle("R2");
    idle(); cycle("R2");
    drive(1, 0, 16'h055, 0, 1, 0, 16'h066, 0); cycle("R2");

    // Mixed traffic biased towards clashes
    for (int n = 0; n < 4000; n++) begin
      int aa, ba, sel;
      aa  = $urandom_range(DEPTH - 1);
      sel = $urandom_range(3);
      case (sel)
        0: ba = aa;
        1: ba = (aa & ~(2**CB - 1)) | $urandom_range(2**CB - 1);
        2: ba = (aa & (2**CB - 1)) | ($urandom_range(DEPTH / 2**CB - 1) << CB);
        default: ba = $urandom_range(DEPTH - 1);
      endcase
      drive($urandom_range(3) != 0, $urandom_range(1) != 0, aa, $urandom,
            $urandom_range(3) != 0, $urandom_range(1) != 0, ba, $urandom);
      cycle("R1");
    end

    // R8: reset mid-run clears outputs but keeps memory
    drive(1, 0, 16'h010, 0, 1, 0, 16'h011, 0);
    rst = 1'b1; cycle("R8");
    rst = 1'b0; idle(); cycle("R8");
    drive(1, 0, 16'h010, 0, 1, 0, 16'h211, 0); cycle("R8");

    idle(); cycle("R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule